// File: doc/BRIEF.md
# Isochronous Endpoint Control and Status Register

This block is the per-endpoint control and status word of a USB device controller, sized for an isochronous endpoint. The USB packet engine reports events to it with single-cycle strobes: an IN transfer acknowledged by the host, a packet stored in receive bank 0 or bank 1 (with its byte count), a setup packet, and an isochronous error. Each event latches a status flag. Firmware clears a flag by writing 0 to its bit. Writing 1 to a status bit leaves that bit as it is, so firmware can clear one flag without a read-modify-write race against the others.

The same word holds the firmware-owned control fields: transmit-ready, force-stall, direction, endpoint type, data toggle and endpoint enable. It also holds the byte count of the last received packet, which is read-only. When firmware clears a receive-bank flag, the block pulses a release strobe that hands the bank back to the engine. After any change of a receive-bank flag, a busy indication guards FIFO access for a settle window. An interrupt request is raised while any status flag is set and the endpoint's interrupt enable is high.

There is no streamed data path here: all pins are plain control and status signals. A write takes effect at the clock edge where `wr_en` is sampled high, and `rd_data` always shows the current register contents.

Top module: `ep_status_reg`

## Requirements
- R1: After reset, `rd_data` reads 0 and `irq`, `fifo_busy`, `bank0_release` and `bank1_release` are all 0.
- R2: The register layout is as follows. Status flags: bit 0 transmit-complete, bit 1 receive-bank-0, bit 2 setup-received, bit 3 isochronous-error, bit 6 receive-bank-1. Control fields: bit 4 transmit-ready, bit 5 force-stall, bit 7 direction, bits 10:8 endpoint type, bit 11 data toggle, bit 15 endpoint enable. Bits 26:16 hold the byte count. All other bits read 0.
- R3: Each event strobe sets its flag, visible on `rd_data` one cycle after the strobe. The mapping is: `ev_bank0_stored` sets bit 1, `ev_setup` sets bit 2, `ev_iso_err` sets bit 3 and `ev_bank1_stored` sets bit 6.
- R4: A write with 0 in a status-flag position clears that flag. A write with 1 in that position leaves the flag unchanged.
- R5: When an event strobe and a clearing write hit the same flag in the same cycle, the flag ends set and no release pulse is produced.
- R6: A write loads the control fields from the written word, and they read back unchanged. Bits outside the layout read 0 whatever was written.
- R7: A bank-0 or bank-1 store event loads `ev_byte_cnt` into bits 26:16. Writes never change the byte count.
- R8: `irq` is 1 exactly while `irq_en` is 1 and at least one status flag is set.
- R9: A write that clears a set receive-bank flag produces a one-cycle pulse on that bank's release output, in the same cycle the flag reads 0.
- R10: After any clock edge where a receive-bank flag changes value, `fifo_busy` is 1 for the next SETTLE cycles (default 3) and 0 afterwards.
- R11: `ev_in_ack` sets transmit-complete (bit 0) and clears transmit-ready (bit 4) only if transmit-ready is set. Otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| ev_in_ack | input | 1 | Host acknowledged an IN transfer |
| ev_bank0_stored | input | 1 | Packet stored in receive bank 0 |
| ev_bank1_stored | input | 1 | Packet stored in receive bank 1 |
| ev_setup | input | 1 | Setup packet received |
| ev_iso_err | input | 1 | Isochronous error detected |
| ev_byte_cnt | input | CNT_W | Byte count of the stored packet |
| irq_en | input | 1 | Endpoint interrupt enable |
| rd_data | output | 32 | Register readback |
| irq | output | 1 | Interrupt request |
| bank0_release | output | 1 | Bank 0 handed back to the engine (pulse) |
| bank1_release | output | 1 | Bank 1 handed back to the engine (pulse) |
| fifo_busy | output | 1 | FIFO access settle guard |

## Verification
A wrong flag state shows on `rd_data` and `irq` in the cycle after the event or write that caused it. Each such state persists until firmware writes the flag, so each test reads the word straight after every stimulus. A lost hardware set in a write collision shows up as a missing bit and a spurious release pulse one cycle later. The settle counter is checked cycle by cycle on `fifo_busy`, so an off-by-one in its load or decrement shows at the third or fourth cycle after a bank flag changes.

// File: rtl/ep_csr_pkg.sv
package ep_csr_pkg;
  localparam int NFLAG     = 5;
  // flag index order inside the block: txcomp, bank0, setup, isoerr, bank1
  localparam int FLAG_POS [NFLAG] = '{0, 1, 2, 3, 6};
  localparam int F_TXC     = 0;
  localparam int F_RB0     = 1;
  localparam int F_RB1     = 4;
  localparam int BIT_TXRDY = 4;
  localparam int BIT_STALL = 5;
  localparam int BIT_DIR   = 7;
  localparam int TYPE_LSB  = 8;
  localparam int TYPE_W    = 3;
  localparam int BIT_TGL   = 11;
  localparam int BIT_EN    = 15;
  localparam int CNT_LSB   = 16;
endpackage

// File: rtl/ep_w0c_flag.sv
module ep_w0c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic fw_wr,
  input  logic fw_bit,
  output logic q,
  output logic chg,
  output logic released
);
  logic d;
  logic fw_clr;

  assign fw_clr = fw_wr & ~fw_bit;

  always_comb begin
    if (hw_set)      d = 1'b1;   // hardware event wins over a clear
    else if (fw_clr) d = 1'b0;
    else             d = q;
  end

  assign chg = d ^ q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q        <= 1'b0;
      released <= 1'b0;
    end else begin
      q        <= d;
      released <= q & fw_clr & ~hw_set;
    end
  end
endmodule

// File: rtl/ep_settle_timer.sv
module ep_settle_timer #(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic busy
);
  localparam int W = $clog2(SETTLE + 1);
  localparam logic [W-1:0] LOAD = W'(SETTLE);
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (trig)      cnt <= LOAD;
    else if (cnt != '0) cnt <= cnt - ONE;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/ep_status_reg.sv
module ep_status_reg
  import ep_csr_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int SETTLE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             ev_in_ack,
  input  logic             ev_bank0_stored,
  input  logic             ev_bank1_stored,
  input  logic             ev_setup,
  input  logic             ev_iso_err,
  input  logic [CNT_W-1:0] ev_byte_cnt,
  input  logic             irq_en,
  output logic [31:0]      rd_data,
  output logic             irq,
  output logic             bank0_release,
  output logic             bank1_release,
  output logic             fifo_busy
);
  logic [NFLAG-1:0]  hw_set, fw_bit, flag_q, flag_chg, flag_rel;
  logic              txrdy_q, stall_q, dir_q, tgl_q, en_q;
  logic [TYPE_W-1:0] type_q;
  logic [CNT_W-1:0]  cnt_q;

  assign hw_set = {ev_bank1_stored, ev_iso_err, ev_setup, ev_bank0_stored,
                   ev_in_ack & txrdy_q};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign fw_bit[i] = wr_data[FLAG_POS[i]];
    ep_w0c_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_set   (hw_set[i]),
      .fw_wr    (wr_en),
      .fw_bit   (fw_bit[i]),
      .q        (flag_q[i]),
      .chg      (flag_chg[i]),
      .released (flag_rel[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txrdy_q <= 1'b0;
      stall_q <= 1'b0;
      dir_q   <= 1'b0;
      type_q  <= '0;
      tgl_q   <= 1'b0;
      en_q    <= 1'b0;
    end else if (wr_en) begin
      txrdy_q <= wr_data[BIT_TXRDY];
      stall_q <= wr_data[BIT_STALL];
      dir_q   <= wr_data[BIT_DIR];
      type_q  <= wr_data[TYPE_LSB +: TYPE_W];
      tgl_q   <= wr_data[BIT_TGL];
      en_q    <= wr_data[BIT_EN];
    end else if (ev_in_ack) begin
      txrdy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  cnt_q <= '0;
    else if (ev_bank0_stored || ev_bank1_stored) cnt_q <= ev_byte_cnt;
  end

  ep_settle_timer #(.SETTLE(SETTLE)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (flag_chg[F_RB0] | flag_chg[F_RB1]),
    .busy  (fifo_busy)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NFLAG; i++) rd_data[FLAG_POS[i]] = flag_q[i];
    rd_data[BIT_TXRDY]             = txrdy_q;
    rd_data[BIT_STALL]             = stall_q;
    rd_data[BIT_DIR]               = dir_q;
    rd_data[TYPE_LSB +: TYPE_W]    = type_q;
    rd_data[BIT_TGL]               = tgl_q;
    rd_data[BIT_EN]                = en_q;
    rd_data[CNT_LSB +: CNT_W]      = cnt_q;
  end

  assign irq           = irq_en & (|flag_q);
  assign bank0_release = flag_rel[F_RB0];
  assign bank1_release = flag_rel[F_RB1];
endmodule

// File: rtl/ep_status_reg_chk.sv
module ep_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        ev_in_ack,
  input logic        ev_bank0_stored,
  input logic        ev_bank1_stored,
  input logic        irq_en,
  input logic [31:0] rd_data,
  input logic        irq,
  input logic        bank0_release,
  input logic        fifo_busy
);
  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bank0_stored |=> rd_data[1]); // R5

  AST_W0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[1] && !ev_bank0_stored) |=> !rd_data[1]); // R4

  AST_W1_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1] && rd_data[1]) |=> rd_data[1]); // R4

  AST_RELEASE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bank0_release |-> (!rd_data[1] && $past(rd_data[1]))); // R9

  AST_BUSY_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] != $past(rd_data[1])) |-> fifo_busy); // R10

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_bank0_stored || ev_bank1_stored) |=> $stable(rd_data[26:16])); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R8

  AST_ACK_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_in_ack && !rd_data[4] && !rd_data[0]) |=> !rd_data[0]); // R11
endmodule

bind ep_status_reg ep_status_reg_chk u_chk (.*);

// File: tb/tb_ep_status_reg.sv
module tb_ep_status_reg;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [31:0]      wr_data = '0;
  logic             ev_in_ack = 1'b0, ev_bank0_stored = 1'b0, ev_bank1_stored = 1'b0;
  logic             ev_setup = 1'b0, ev_iso_err = 1'b0;
  logic [CNT_W-1:0] ev_byte_cnt = '0;
  logic             irq_en = 1'b0;
  logic [31:0]      rd_data;
  logic             irq, bank0_release, bank1_release, fifo_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_status_reg #(.CNT_W(CNT_W), .SETTLE(3)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, advance one edge, sample at next negedge
  task automatic step();
    @(negedge clk);
    wr_en = 1'b0; ev_in_ack = 1'b0; ev_bank0_stored = 1'b0; ev_bank1_stored = 1'b0;
    ev_setup = 1'b0; ev_iso_err = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
  endtask

  task automatic t_reset();
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 busy", {31'b0, fifo_busy}, 32'h0);
    check("R1 release", {30'b0, bank1_release, bank0_release}, 32'h0);
  endtask

  task automatic t_ctrl();
    wr(32'hFFFF_FBEF);
    check("R6 R2 R7 control readback", rd_data, 32'h0000_8BA0);
    check("R4 write-one sets nothing", {31'b0, irq_en & irq}, 32'h0);
    wr(32'h0000_0000);
    check("R6 control cleared", rd_data, 32'h0);
  endtask

  task automatic t_bank0();
    irq_en = 1'b1;
    ev_bank0_stored = 1'b1; ev_byte_cnt = 11'h5A3;
    step();
    check("R3 R7 bank0 set with count", rd_data, 32'h05A3_0002);
    check("R8 irq on", {31'b0, irq}, 32'h1);
    check("R10 busy cycle 1", {31'b0, fifo_busy}, 32'h1);
    step();
    check("R10 busy cycle 2", {31'b0, fifo_busy}, 32'h1);
    step();
    check("R10 busy cycle 3", {31'b0, fifo_busy}, 32'h1);
    step();
    check("R10 busy ends", {31'b0, fifo_busy}, 32'h0);
    wr(32'h0000_0002);
    check("R4 write one keeps bank0", rd_data, 32'h05A3_0002);
    check("R7 write leaves count", rd_data[26:16], 32'h5A3);
    wr(32'h0000_0000);
    check("R4 write zero clears bank0", rd_data, 32'h05A3_0000);
    check("R9 bank0 release pulse", {31'b0, bank0_release}, 32'h1);
    check("R10 busy after clear", {31'b0, fifo_busy}, 32'h1);
    check("R8 irq off", {31'b0, irq}, 32'h0);
    step();
    check("R9 release one cycle", {31'b0, bank0_release}, 32'h0);
    repeat (3) step();
  endtask

  task automatic t_flags();
    irq_en = 1'b0;
    ev_setup = 1'b1; step();
    check("R3 setup bit2", rd_data[7:0], 32'h04);
    ev_iso_err = 1'b1; step();
    check("R3 iso error bit3", rd_data[7:0], 32'h0C);
    ev_bank1_stored = 1'b1; ev_byte_cnt = 11'h011; step();
    check("R3 R7 bank1 bit6 and count", rd_data, 32'h0011_004C);
    check("R8 irq masked", {31'b0, irq}, 32'h0);
    irq_en = 1'b1; #1;
    check("R8 irq enabled", {31'b0, irq}, 32'h1);
    wr(32'h0000_000F);
    check("R4 clear bank1 only", rd_data[7:0], 32'h0C);
    check("R9 bank1 release", {31'b0, bank1_release}, 32'h1);
    check("R9 no bank0 release", {31'b0, bank0_release}, 32'h0);
    wr(32'h0000_0000);
    check("R4 all cleared", rd_data[7:0], 32'h00);
    repeat (4) step();
  endtask

  task automatic t_tx();
    ev_in_ack = 1'b1; step();
    check("R11 ack ignored without ready", rd_data[7:0], 32'h00);
    wr(32'h0000_0010);
    check("R6 tx ready set", rd_data[7:0], 32'h10);
    ev_in_ack = 1'b1; step();
    check("R11 ack sets txcomp clears ready", rd_data[7:0], 32'h01);
    check("R8 irq from txcomp", {31'b0, irq}, 32'h1);
    wr(32'h0000_0000);
    check("R4 txcomp cleared", rd_data[7:0], 32'h00);
  endtask

  task automatic t_race();
    ev_bank0_stored = 1'b1; ev_byte_cnt = 11'h7FF; step();
    repeat (3) step();
    ev_bank0_stored = 1'b1; ev_byte_cnt = 11'h123;
    wr(32'h0000_0000);
    check("R5 set wins over clear", rd_data, 32'h0123_0002);
    check("R5 no release on collision", {31'b0, bank0_release}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_bank0();
    t_flags();
    t_tx();
    t_race();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule